// File: doc/BRIEF.md
# SCL Waveform Generator

This block times the serial clock of a two-wire bus master from the system clock. One configuration word holds a shared power-of-two prescale exponent and two 8-bit divisors, one for each phase. A fixed offset, set per variant as a module parameter, is added to both phases. The low phase lasts `lo_div * 2^exp + OFFSET` system clocks and the high phase lasts `hi_div * 2^exp + OFFSET` system clocks. Equal divisors give a symmetric clock. Typical settings target a 100 kHz bus, and 400 kHz is the fastest rate supported.

While it runs, the generator drives SCL low for the low phase and releases it for the high phase. It raises a change strobe in the middle of each low phase, which is where the byte engine moves SDA. It raises a sample strobe in the middle of the counted high time, which is where the byte engine samples SDA. A target may hold the released line low to stretch the clock. The high-phase count waits until the line reads high, so a stretch lengthens the high phase. The configuration is captured only when a low phase begins, so a period already in progress is never cut short or stretched by a new setting. Start and stop sequencing and data shifting belong to the controller around this block.

Top module: `scl_wave_gen`

## Requirements
- R1: In `wave_cfg`, bits 7:0 hold the low divisor, bits 15:8 hold the high divisor and bits 18:16 hold the exponent.
- R2: During a low phase `scl_oe` is 1 for exactly `lo_div * 2^exp + OFFSET` consecutive cycles.
- R3: Without stretching, a high phase (`scl_oe` = 0 between two low phases) lasts exactly `hi_div * 2^exp + OFFSET` cycles.
- R4: An exponent field larger than `MAX_EXP` is treated as `MAX_EXP`.
- R5: The configuration is captured at the start of each low phase and applies to that low phase and the high phase after it. A write made during a period first affects the next period.
- R6: During a high phase, a cycle in which `scl_in` reads 0 does not count toward the phase length. Each such cycle extends the high phase by one cycle.
- R7: `chg_stb` pulses exactly once per low phase, in cycle index floor(Llow/2) counted from 0 at the start of the phase.
- R8: `smp_stb` pulses exactly once per high phase, in cycle index S + floor(Lhigh/2), where S is the number of stretched cycles at the start of the phase.
- R9: When `run` is 0 at the end of a high phase, SCL stays released (`scl_oe` = 0) with no strobes until `run` is seen high again. A new burst starts with a low phase.
- R10: One cycle after `soft_rst` is seen, `scl_oe`, `chg_stb` and `smp_stb` are 0. They stay 0 while `soft_rst` is held, even with `run` = 1.
- R11: After reset, `scl_oe`, `chg_stb` and `smp_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous stop: counters cleared, SCL released |
| run | input | 1 | Keep generating clock periods while high |
| wave_cfg | input | 19 | Exponent, high divisor and low divisor fields |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| chg_stb | output | 1 | SDA change point, middle of the low phase |
| smp_stb | output | 1 | SDA sample point, middle of the counted high time |

## Verification
The bench builds the generator with `OFFSET` = 3 and `MAX_EXP` = 2. The short phase lengths that follow (3 to 15 cycles) make it cheap to measure every period exactly. Because `MAX_EXP` is small, a written exponent of 7 hits the clamp. Zero divisors drive the phase length down to the bare offset, which puts the midpoint strobes next to the phase edges. A modelled target stretches the clock for five cycles, which shifts the sample strobe and lengthens the high phase by a known amount.

// File: rtl/scl_wg_pkg.sv
package scl_wg_pkg;

  typedef enum logic [1:0] {
    WG_IDLE = 2'd0,
    WG_LOW  = 2'd1,
    WG_HIGH = 2'd2
  } wg_state_e;

  // exponent limited to the variant maximum
  function automatic int unsigned wg_clamp_exp(input int unsigned e, input int unsigned emax);
    return (e > emax) ? emax : e;
  endfunction

  // phase length in system clocks, never below one
  function automatic int unsigned wg_phase_len(input int unsigned dv, input int unsigned e,
                                               input int unsigned off);
    int unsigned l;
    l = (dv << e) + off;
    return (l == 0) ? 1 : l;
  endfunction

  // index of the strobe cycle inside a phase
  function automatic int unsigned wg_mid(input int unsigned len);
    return len / 2;
  endfunction

endpackage

// File: rtl/scl_wg_cfg.sv
module scl_wg_cfg
  import scl_wg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  parameter int OFFSET  = 4,
  parameter int LEN_W   = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [2*DIV_W+EXP_W-1:0]   cfg_i,
  output logic [LEN_W-1:0]           len_lo_o,
  output logic [LEN_W-1:0]           len_hi_o
);

  logic [DIV_W-1:0] lo_f;
  logic [DIV_W-1:0] hi_f;
  logic [EXP_W-1:0] exp_f;
  int unsigned      exp_eff;
  logic [LEN_W-1:0] lo_nxt;
  logic [LEN_W-1:0] hi_nxt;

  assign lo_f  = cfg_i[DIV_W-1:0];
  assign hi_f  = cfg_i[2*DIV_W-1:DIV_W];
  assign exp_f = cfg_i[2*DIV_W+EXP_W-1:2*DIV_W];

  always_comb begin
    exp_eff = wg_clamp_exp(32'(exp_f), MAX_EXP);
    lo_nxt  = LEN_W'(wg_phase_len(32'(lo_f), exp_eff, OFFSET));
    hi_nxt  = LEN_W'(wg_phase_len(32'(hi_f), exp_eff, OFFSET));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_lo_o <= LEN_W'(1);
      len_hi_o <= LEN_W'(1);
    end else if (load) begin
      len_lo_o <= lo_nxt;
      len_hi_o <= hi_nxt;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(len_lo_o) && $stable(len_hi_o))); // R5

endmodule

// File: rtl/scl_wg_ctr.sv
module scl_wg_ctr #(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [LEN_W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (clr) cnt_o <= '0;
    else if (adv) cnt_o <= cnt_o + LEN_W'(1);
  end

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_wg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  parameter int OFFSET  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     run,
  input  logic [2*DIV_W+EXP_W-1:0] wave_cfg,
  input  logic                     scl_in,
  output logic                     scl_oe,
  output logic                     chg_stb,
  output logic                     smp_stb
);

  localparam int LEN_W = DIV_W + MAX_EXP + 2;

  wg_state_e        state_q;
  wg_state_e        state_d;
  logic [LEN_W-1:0] len_lo;
  logic [LEN_W-1:0] len_hi;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] mid_lo;
  logic [LEN_W-1:0] mid_hi;

  // named internal events
  logic st_low, st_high, st_idle;
  logic low_done, high_done, phase_start, ctr_clr, ctr_adv;

  assign st_idle = (state_q == WG_IDLE);
  assign st_low  = (state_q == WG_LOW);
  assign st_high = (state_q == WG_HIGH);

  assign low_done    = st_low && (cnt == len_lo - LEN_W'(1));
  assign high_done   = st_high && scl_in && (cnt == len_hi - LEN_W'(1));
  assign phase_start = !soft_rst && ((st_idle && run) || (high_done && run));
  assign ctr_clr     = soft_rst || st_idle || low_done || high_done;
  assign ctr_adv     = st_low || (st_high && scl_in);

  assign mid_lo = LEN_W'(wg_mid(32'(len_lo)));
  assign mid_hi = LEN_W'(wg_mid(32'(len_hi)));

  scl_wg_cfg #(
    .DIV_W  (DIV_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP),
    .OFFSET (OFFSET),
    .LEN_W  (LEN_W)
  ) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (phase_start),
    .cfg_i   (wave_cfg),
    .len_lo_o(len_lo),
    .len_hi_o(len_hi)
  );

  scl_wg_ctr #(.LEN_W(LEN_W)) ctr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctr_clr),
    .adv  (ctr_adv),
    .cnt_o(cnt)
  );

  always_comb begin
    state_d = state_q;
    if (soft_rst) begin
      state_d = WG_IDLE;
    end else begin
      unique case (state_q)
        WG_IDLE: if (run)       state_d = WG_LOW;
        WG_LOW:  if (low_done)  state_d = WG_HIGH;
        WG_HIGH: if (high_done) state_d = run ? WG_LOW : WG_IDLE;
        default: state_d = WG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WG_IDLE;
    else        state_q <= state_d;
  end

  assign scl_oe  = st_low;
  assign chg_stb = st_low && (cnt == mid_lo);
  assign smp_stb = st_high && scl_in && (cnt == mid_hi);

  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!scl_oe && !chg_stb && !smp_stb)); // R10

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_high && !scl_in && !soft_rst) |=> (st_high && (cnt == $past(cnt)))); // R6

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_low |-> (cnt < len_lo)); // R2

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_high |-> (cnt < len_hi)); // R3

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done && !run && !soft_rst) |=> (st_idle && !scl_oe)); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_stb, smp_stb})); // R7

endmodule

// File: tb/scl_wave_gen_tb_top.sv
module scl_wave_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OFF  = 3;
  localparam int EMAX = 2;

  typedef struct {
    int    len;
    int    mid;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        run = 1'b0;
  logic [18:0] wave_cfg = '0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_oe, chg_stb, smp_stb;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit discard = 1'b0;
  bit done = 1'b0;

  exp_t lo_q[$];
  exp_t hi_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain line: released and not held by the target
  assign scl_in = !scl_oe && !hold;

  scl_wave_gen #(.OFFSET(OFF), .MAX_EXP(EMAX)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .run     (run),
    .wave_cfg(wave_cfg),
    .scl_in  (scl_in),
    .scl_oe  (scl_oe),
    .chg_stb (chg_stb),
    .smp_stb (smp_stb)
  );

  // R1 field layout: exponent 18:16, high divisor 15:8, low divisor 7:0
  function automatic logic [18:0] mk(input int e, input int hi, input int lo);
    return {3'(e), 8'(hi), 8'(lo)};
  endfunction

  function automatic int ref_len(input int dv, input int e);
    int ee;
    ee = (e < EMAX) ? e : EMAX;
    return dv * (1 << ee) + OFF;
  endfunction

  function automatic int lo_of(input logic [18:0] c);
    return ref_len(int'(c[7:0]), int'(c[18:16]));
  endfunction

  function automatic int hi_of(input logic [18:0] c);
    return ref_len(int'(c[15:8]), int'(c[18:16]));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: measures each phase and compares with the scoreboard
  bit   prev_oe = 1'b0;
  bit   in_high = 1'b0;
  int   lcnt, lmid, lnum, hcnt, hmid, hnum;

  always @(negedge clk) begin
    if (discard) begin
      in_high = 1'b0;
      discard = 1'b0;
    end
    if (!mon_en) begin
      in_high = 1'b0;
      prev_oe = scl_oe;
    end else begin
      if (scl_oe) begin
        if (!prev_oe) begin
          if (in_high) begin
            if (hi_q.size() == 0) chk(1'b0, "R9", "unexpected high phase", hcnt, 0);
            else begin
              exp_t e;
              e = hi_q.pop_front();
              chk(hcnt == e.len, e.tag, "high length", hcnt, e.len);
              chk(hnum == 1 && hmid == e.mid, e.tag, "R8 sample strobe index", hmid, e.mid);
            end
          end
          in_high = 1'b0;
          lcnt = 0; lnum = 0; lmid = -1;
        end
        if (chg_stb) begin lmid = lcnt; lnum++; end
        if (smp_stb) chk(1'b0, "R8", "sample strobe in low phase", 1, 0);
        lcnt++;
      end else begin
        if (prev_oe) begin
          if (lo_q.size() == 0) chk(1'b0, "R9", "unexpected low phase", lcnt, 0);
          else begin
            exp_t e;
            e = lo_q.pop_front();
            chk(lcnt == e.len, e.tag, "low length", lcnt, e.len);
            chk(lnum == 1 && lmid == e.mid, e.tag, "R7 change strobe index", lmid, e.mid);
          end
          in_high = 1'b1;
          hcnt = 0; hnum = 0; hmid = -1;
        end
        if (in_high) begin
          if (smp_stb) begin hmid = hcnt; hnum++; end
          if (chg_stb) chk(1'b0, "R7", "change strobe in high phase", 1, 0);
          hcnt++;
        end else if (chg_stb || smp_stb) begin
          chk(1'b0, "R9", "strobe while idle", 1, 0);
        end
      end
      prev_oe = scl_oe;
    end
  end

  // driver: pushes the expected phases, then runs n periods
  task automatic burst(input logic [18:0] c1, input logic [18:0] c2, input int n,
                       input int s, input string tg);
    for (int k = 0; k < n; k++) begin
      logic [18:0] c;
      exp_t e;
      c = (k == 0) ? c1 : c2;
      e.len = lo_of(c); e.mid = lo_of(c) / 2; e.tag = tg;
      lo_q.push_back(e);
      if (k < n - 1) begin
        e.len = hi_of(c) + s; e.mid = s + hi_of(c) / 2; e.tag = tg;
        hi_q.push_back(e);
      end
    end
    @(posedge clk); #1;
    wave_cfg = c1;
    run = 1'b1;
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!scl_oe);
      if (k == 0) wave_cfg = c2;
      if (s > 0) hold = 1'b1;
      do @(negedge clk); while (scl_oe);
      if (k == n - 1) run = 1'b0;
      if (s > 0) begin
        repeat (s) @(posedge clk);
        #1 hold = 1'b0;
      end
    end
    repeat (hi_of(c2) + s + 6) @(negedge clk);
    // R9: line released after the last period ends with run low
    chk(!scl_oe && !chg_stb && !smp_stb, "R9", "released after burst", int'(scl_oe), 0);
    discard = 1'b1;
    @(negedge clk);
    chk(lo_q.size() == 0 && hi_q.size() == 0, tg, "scoreboard drained", lo_q.size() + hi_q.size(), 0);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!scl_oe && !chg_stb && !smp_stb, "R11", "outputs in reset", int'(scl_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !chg_stb && !smp_stb, "R11", "outputs after reset", int'(scl_oe), 0);
    // R9: idle without run
    repeat (10) begin
      @(negedge clk);
      chk(!scl_oe && !chg_stb && !smp_stb, "R9", "idle with run low", int'(scl_oe), 0);
    end
    mon_en = 1'b1;
    @(negedge clk);

    burst(mk(0, 4, 4), mk(0, 4, 4), 3, 0, "R1 R2 R3");
    burst(mk(1, 2, 5), mk(1, 2, 5), 3, 0, "R1 R2 R3");
    burst(mk(7, 3, 1), mk(7, 3, 1), 2, 0, "R4");
    burst(mk(0, 0, 0), mk(0, 0, 0), 2, 0, "R2 R3 R7 R8");
    burst(mk(0, 4, 4), mk(1, 2, 5), 3, 0, "R5");
    burst(mk(0, 4, 4), mk(0, 4, 4), 3, 5, "R6 R8");

    // R10: soft reset in the middle of a low phase, run kept high
    mon_en = 1'b0;
    @(posedge clk); #1;
    wave_cfg = mk(1, 2, 5);
    run = 1'b1;
    do @(negedge clk); while (!scl_oe);
    repeat (2) @(negedge clk);
    soft_rst = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!scl_oe && !chg_stb && !smp_stb, "R10", "quiet under soft reset", int'(scl_oe), 0);
    end
    soft_rst = 1'b0;
    run = 1'b0;
    repeat (4) @(negedge clk);
    chk(!scl_oe, "R10", "idle after soft reset", int'(scl_oe), 0);
    mon_en = 1'b1;
    @(negedge clk);
    burst(mk(1, 2, 5), mk(1, 2, 5), 2, 0, "R10");

    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      report();
    end
  end

endmodule